// File: doc/BRIEF.md
# Interleaved Dual-Channel Sample Capture

This block takes one shared byte-wide bus on which the samples of two output channels arrive in turn, one in each half of the sample clock. The channel-2 sample is on the bus while the clock is high and is caught on the falling edge into a holding register. The channel-1 sample follows while the clock is low and is caught on the next rising edge. On that same rising edge the held channel-2 sample moves into its output register. The two channel words that feed the downstream converters therefore always change together, as one aligned pair.

An active-low select gates all capture. A pair whose channel-2 half arrived while the select was high is dropped, and the outputs keep their last pair. A strobe marks each cycle in which a new pair has been presented. A valid flag goes high once the first complete pair has been delivered and stays high until reset. Reset is synchronous and active high, and it is applied on both clock edges.

Top module: `dual_lane_capture`

## Requirements
- R1: While reset is high, both channel outputs read 0x00 and the strobe and valid flag are low. One rising edge with reset high is enough to reach this state.
- R2: When the select is low at a falling edge and at the following rising edge, the channel-1 output after that rising edge equals the bus value present at that rising edge. Bit 7 of each word is the MSB.
- R3: Under the same condition, the channel-2 output after that rising edge equals the bus value captured at the preceding falling edge.
- R4: Both channel outputs change only on a rising edge that carries a transfer, and they change on the same edge.
- R5: If the select is high at a rising edge, neither channel output changes on that edge and the strobe is low in the following cycle.
- R6: If the select is high at a falling edge, the following rising edge makes no transfer, even when the select is low at that rising edge. The holding register keeps its content while the select is high.
- R7: The strobe is high for exactly the cycles that follow a rising edge with a transfer, and low otherwise.
- R8: The valid flag stays low after reset until the first transfer. It is high from that transfer onward and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges capture |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select gating capture |
| bus_in | input | 8 | Shared interleaved sample bus |
| lane1_out | output | 8 | Registered channel-1 word |
| lane2_out | output | 8 | Registered channel-2 word, aligned with channel 1 |
| upd_stb | output | 1 | High for one cycle after each pair update |
| pair_valid | output | 1 | High once a complete pair has been presented |

## Verification
The hardest case to reach is a split select: the select is high only at the falling edge and low at the following rising edge. In that case a half-captured pair must be dropped, even though the rising-edge condition alone would allow a transfer. The stimulus reaches this case by driving the select separately for each half-cycle, changing it a little after each edge. The vector table mixes this split case, the opposite split, and gaps with both halves deselected in between back-to-back transfers. Each pair uses distinct values such as 0x7F and 0x80 in each half, so that swapped or stale halves show up at the outputs.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    // Default sample width of the shared bus and of each channel word.
    localparam int DLC_WORD_W = 8;
endpackage

// File: rtl/dlc_hold_stage.sv
module dlc_hold_stage #(
    parameter int W = dlc_pkg::DLC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] hold_word,
    output logic         hold_ok
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         ok;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (rst) begin
            hold_d = '0;
        end else if (!cs_n) begin
            hold_d.word = bus_in;
            hold_d.ok   = 1'b1;
        end else begin
            // Deselected half: keep the word, but mark the pair incomplete.
            hold_d.ok   = 1'b0;
        end
    end

    always_ff @(negedge clk) begin
        hold_q <= hold_d;
    end

    assign hold_word = hold_q.word;
    assign hold_ok   = hold_q.ok;

    // R6
    hold_keep_chk: assert property (@(negedge clk) disable iff (rst)
        cs_n |=> ($stable(hold_q.word) && !hold_q.ok));
endmodule

// File: rtl/dlc_pair_xfer.sv
module dlc_pair_xfer #(
    parameter int W = dlc_pkg::DLC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] hold_word,
    input  logic         hold_ok,
    output logic [W-1:0] lane1_out,
    output logic [W-1:0] lane2_out,
    output logic         upd_stb,
    output logic         pair_valid
);
    typedef struct packed {
        logic [W-1:0] lane1;
        logic [W-1:0] lane2;
        logic         stb;
        logic         valid;
    } xfer_t;

    xfer_t xfer_d, xfer_q;
    logic  take_pair;

    assign take_pair = !cs_n && hold_ok;

    always_comb begin
        xfer_d     = xfer_q;
        xfer_d.stb = 1'b0;
        if (rst) begin
            xfer_d = '0;
        end else if (take_pair) begin
            xfer_d.lane1 = bus_in;
            xfer_d.lane2 = hold_word;
            xfer_d.stb   = 1'b1;
            xfer_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        xfer_q <= xfer_d;
    end

    assign lane1_out  = xfer_q.lane1;
    assign lane2_out  = xfer_q.lane2;
    assign upd_stb    = xfer_q.stb;
    assign pair_valid = xfer_q.valid;

    // R5
    desel_still_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && !$past(rst)) |-> ($stable(xfer_q.lane1) && $stable(xfer_q.lane2)));

    // R4
    quiet_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer_q.stb && !$past(rst)) |-> ($stable(xfer_q.lane1) && $stable(xfer_q.lane2)));

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_q.valid |=> xfer_q.valid);

    // R7
    stb_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_q.stb |-> xfer_q.valid);
endmodule

// File: rtl/dual_lane_capture.sv
module dual_lane_capture #(
    parameter int W = dlc_pkg::DLC_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] lane1_out,
    output logic [W-1:0] lane2_out,
    output logic         upd_stb,
    output logic         pair_valid
);
    logic [W-1:0] hold_word;
    logic         hold_ok;

    dlc_hold_stage #(.W(W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .bus_in    (bus_in),
        .hold_word (hold_word),
        .hold_ok   (hold_ok)
    );

    dlc_pair_xfer #(.W(W)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .bus_in     (bus_in),
        .hold_word  (hold_word),
        .hold_ok    (hold_ok),
        .lane1_out  (lane1_out),
        .lane2_out  (lane2_out),
        .upd_stb    (upd_stb),
        .pair_valid (pair_valid)
    );

    // R6
    half_pair_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_ok |=> !upd_stb);

    // R2
    lane1_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && hold_ok) |=> (upd_stb && lane1_out == $past(bus_in)));
endmodule

// File: tb/sim_dual_lane_capture.sv
module sim_dual_lane_capture;
    localparam int CLK_P = 20;
    localparam int NV    = 12;
    // Each entry: {select at falling half, select at rising half, ch2 word, ch1 word}
    localparam logic [17:0] VEC [NV] = '{
        {2'b00, 8'hA5, 8'h5A},
        {2'b00, 8'hFF, 8'h00},
        {2'b00, 8'h00, 8'hFF},
        {2'b00, 8'h7F, 8'h80},
        {2'b10, 8'h33, 8'h44},
        {2'b01, 8'h55, 8'h66},
        {2'b00, 8'h12, 8'h34},
        {2'b11, 8'h99, 8'h88},
        {2'b00, 8'h80, 8'h7F},
        {2'b00, 8'h01, 8'hFE},
        {2'b00, 8'hC3, 8'h3C},
        {2'b10, 8'hEE, 8'hDD}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] lane1_out, lane2_out;
    logic       upd_stb, pair_valid;

    int errors = 0;
    int checks = 0;
    logic [7:0] e1 = 8'h00, e2 = 8'h00;
    logic       ev = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_lane_capture u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .bus_in     (bus_in),
        .lane1_out  (lane1_out),
        .lane2_out  (lane2_out),
        .upd_stb    (upd_stb),
        .pair_valid (pair_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts a little after a rising edge, ends a little after the next one.
    task automatic half_pair(input logic csa, input logic csb,
                             input logic [7:0] c2, input logic [7:0] c1);
        cs_n = csa; bus_in = c2;
        @(negedge clk); #2;
        cs_n = csb; bus_in = c1;
        @(posedge clk); #2;
    endtask

    task automatic check_pair(input string tag, input logic take);
        chk({tag, " lane1"}, lane1_out, e1);
        chk({tag, " lane2"}, lane2_out, e2);
        chk({tag, " strobe"}, upd_stb, take);
        chk({tag, " valid"}, pair_valid, ev);
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1; bus_in = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        e1 = 8'h00; e2 = 8'h00; ev = 1'b0;
    endtask

    initial begin
        #(CLK_P * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check_pair("R1 after reset", 1'b0);

        // R8: a half-deselected pair must not set valid
        half_pair(1'b1, 1'b0, 8'h21, 8'h43);
        check_pair("R8 no valid before first pair", 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic take;
            take = !VEC[i][17] && !VEC[i][16];
            half_pair(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            if (take) begin
                e1 = VEC[i][7:0]; e2 = VEC[i][15:8]; ev = 1'b1;
                check_pair("R2 R3 R4 aligned pair", take);
            end else if (VEC[i][17]) begin
                check_pair("R6 dropped half pair", take);
            end else begin
                check_pair("R5 deselected rising half", take);
            end
        end

        // R7: strobe falls after an idle cycle following a transfer
        half_pair(1'b0, 1'b0, 8'h6B, 8'hB6);
        e1 = 8'hB6; e2 = 8'h6B; ev = 1'b1;
        check_pair("R7 transfer", 1'b1);
        half_pair(1'b1, 1'b1, 8'h00, 8'h00);
        check_pair("R7 idle after transfer", 1'b0);

        // R1: reset in mid-run clears everything
        do_reset();
        check_pair("R1 mid-run reset", 1'b0);

        // R6: the word held before reset must not leak into a later pair
        half_pair(1'b1, 1'b0, 8'hAA, 8'h55);
        check_pair("R6 post-reset half pair", 1'b0);
        half_pair(1'b0, 1'b0, 8'h0F, 8'hF0);
        e1 = 8'hF0; e2 = 8'h0F; ev = 1'b1;
        check_pair("R2 R3 first pair after reset", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule